// File: doc/BRIEF.md
# Lockable Associative Translation Buffer With Contexts

This block is a fully associative address translation cache. Each of its entries caches one 8 KiB virtual page. An entry holds the virtual page number (address bits 63..13), a 13-bit context number, a global flag, a lock flag and a 64-bit attribute word. The attribute word carries the physical page number and the permission bits. A lookup port takes a 64-bit virtual address, the current context, an access kind (read or write) and the privilege mode. One clock later it returns hit or miss, the 41-bit physical address, the cached attribute word and a protection fault indication.

A maintenance port runs three commands, one per cycle: insert an entry, invalidate the entries that match an address, and flush one context. An insert first reuses any entry that already caches the same page under the same context. Failing that, it takes a free slot, and failing that, the least recently used entry that is not locked. Lookup hits and inserts both count as uses. Entries that are locked are never chosen for eviction. If every slot is valid and locked, the insert is refused and an error pulse is raised. Refilling after a miss and walking page tables are handled outside this block.

Top module: `assoc_tlb`

## Requirements
- R1: After reset no entry is valid: every lookup reports a miss, with no fault, and the insert error output is low.
- R2: A lookup presented on `lk_vld` is answered exactly one cycle later on `res_vld`. On a hit, `res_pa` is the attribute word's bits 40..13 followed by the lookup address bits 12..0, and `res_attr` is the stored attribute word.
- R3: An entry hits only when it is valid and its page number equals lookup address bits 63..13. In addition, either its context equals `lk_ctx` or its global flag was set at insert. Otherwise the lookup misses.
- R4: A hit raises `res_fault` when a write (`lk_write`=1) meets an attribute word with bit 1 (writable) clear. It also raises `res_fault` when a user-mode access (`lk_user`=1) meets bit 2 (privileged) set. A miss never raises `res_fault`.
- R5: An insert (`mnt_op`=1) whose page matches an existing entry with the same context, or with the global flag set on either side, overwrites that entry in place. No two entries ever hit the same lookup.
- R6: Invalidate (`mnt_op`=2) removes every entry that an insert with the same page, context and global flag would match, whether or not it is locked.
- R7: Flush (`mnt_op`=3) removes every entry whose context equals `mnt_ctx` and that is neither locked nor global. All other entries stay.
- R8: When no entry matches and a free slot exists, an insert fills the lowest-numbered free slot. When all slots are valid, it replaces the least recently used unlocked entry, where both lookup hits and inserts count as uses.
- R9: An entry inserted with attribute bit 6 (lock) set is never evicted by an insert for a different page.
- R10: When all entries are valid and locked, an insert for a new page changes nothing and drives `mnt_err` high for one cycle, in the cycle after the command.
- R11: The size code in attribute bits 62..61 is stored but does not widen matching. An entry inserted with size code 3 still misses for an address whose bit 13 differs.
- R12: An insert whose attribute bit 63 (valid) is clear leaves the target slot invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Current context number |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is from user mode |
| res_vld | output | 1 | Lookup result valid (one cycle after request) |
| res_hit | output | 1 | Lookup hit |
| res_fault | output | 1 | Protection fault on a hit |
| res_pa | output | 41 | Translated physical address |
| res_attr | output | 64 | Attribute word of the hitting entry |
| mnt_op | input | 2 | 0 none, 1 insert, 2 invalidate, 3 flush context |
| mnt_va | input | 64 | Maintenance virtual address |
| mnt_ctx | input | 13 | Maintenance context number |
| mnt_glob | input | 1 | Global flag for insert and invalidate |
| mnt_attr | input | 64 | Attribute word for insert |
| mnt_err | output | 1 | Insert refused because all entries are locked |

## Verification
On every cycle the assertions check the following. A result follows each lookup after exactly one cycle. A fault never comes without a hit. The page offset of the result passes straight through from the address. At most one entry matches any lookup. A locked valid entry disappears only through an invalidate or an insert. An error pulse only follows an insert. The bench scenarios are needed for properties that depend on history: the order of least recent use across a fill followed by a touch, the survival of locked entries through eviction and flush, a completely locked array refusing an insert, and size codes that do not widen a match.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 64;
  localparam int PG_SHIFT = 13;
  localparam int CTX_W    = 13;
  localparam int PA_W     = 41;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int PPN_W    = PA_W - PG_SHIFT;

  localparam int ATTR_VALID = 63;
  localparam int ATTR_LOCK  = 6;
  localparam int ATTR_PRIV  = 2;
  localparam int ATTR_WR    = 1;

  typedef enum logic [1:0] {
    MOP_NONE   = 2'd0,
    MOP_INSERT = 2'd1,
    MOP_INVAL  = 2'd2,
    MOP_FLUSH  = 2'd3
  } mop_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int NUM_ENT = 16,
  parameter int VPN_W   = 51,
  parameter int CTX_W   = 13
) (
  input  logic [NUM_ENT-1:0] ent_vld,
  input  logic [NUM_ENT-1:0] ent_glob,
  input  logic [VPN_W-1:0]   ent_vpn [NUM_ENT],
  input  logic [CTX_W-1:0]   ent_ctx [NUM_ENT],
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [CTX_W-1:0]   key_ctx,
  input  logic               key_glob,
  output logic [NUM_ENT-1:0] match
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic vpn_eq, ctx_ok;
    assign vpn_eq   = (ent_vpn[g] == key_vpn);
    assign ctx_ok   = ent_glob[g] | key_glob | (ent_ctx[g] == key_ctx);
    assign match[g] = ent_vld[g] & vpn_eq & ctx_ok;
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int NUM_ENT = 16,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IW-1:0]      touch_idx,
  input  logic [NUM_ENT-1:0] ent_vld,
  input  logic [NUM_ENT-1:0] ent_lock,
  output logic               vict_ok,
  output logic [IW-1:0]      vict_idx
);
  logic [IW-1:0] age_q [NUM_ENT];
  logic [IW-1:0] age_d [NUM_ENT];

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (i == int'(touch_idx))             age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < NUM_ENT; i++) age_q[i] <= age_d[i];
    end
  end

  // Free slot first (lowest index), else oldest unlocked valid entry.
  always_comb begin
    logic          got_free, got_old;
    logic [IW-1:0] free_idx, old_idx, old_age;
    got_free = 1'b0; got_old = 1'b0;
    free_idx = '0;   old_idx = '0; old_age = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        got_free = 1'b1;
        free_idx = IW'(i);
      end
    end
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ent_vld[i] && !ent_lock[i] && (!got_old || age_q[i] > old_age)) begin
        got_old = 1'b1;
        old_idx = IW'(i);
        old_age = age_q[i];
      end
    end
    vict_ok  = got_free | got_old;
    vict_idx = got_free ? free_idx : old_idx;
  end
endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_vld,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic              res_vld,
  output logic              res_hit,
  output logic              res_fault,
  output logic [PA_W-1:0]   res_pa,
  output logic [63:0]       res_attr,
  input  logic [1:0]        mnt_op,
  input  logic [VA_W-1:0]   mnt_va,
  input  logic [CTX_W-1:0]  mnt_ctx,
  input  logic              mnt_glob,
  input  logic [63:0]       mnt_attr,
  output logic              mnt_err
);
  // Entry storage
  logic [NUM_ENT-1:0] vld_q, lock_q, glob_q, vld_d, lock_d, glob_d;
  logic [VPN_W-1:0]   vpn_q [NUM_ENT];
  logic [CTX_W-1:0]   ctx_q [NUM_ENT];
  logic [63:0]        attr_q [NUM_ENT];
  logic               wr_en;
  logic [IW-1:0]      wr_idx;

  // Lookup path
  logic [NUM_ENT-1:0] lk_match;
  logic               lk_any;
  logic [IW-1:0]      lk_idx;
  logic [63:0]        lk_attr;
  logic               lk_fault;

  // Maintenance path
  mop_e               op;
  logic [NUM_ENT-1:0] mnt_match;
  logic               dup_any;
  logic [IW-1:0]      dup_idx;
  logic               vict_ok;
  logic [IW-1:0]      vict_idx;
  logic               ins_refuse;
  logic               touch_en;
  logic [IW-1:0]      touch_idx;

  assign op = mop_e'(mnt_op);

  tlb_cam #(.NUM_ENT(NUM_ENT), .VPN_W(VPN_W), .CTX_W(CTX_W)) lk_cam_i (
    .ent_vld(vld_q), .ent_glob(glob_q), .ent_vpn(vpn_q), .ent_ctx(ctx_q),
    .key_vpn(lk_va[VA_W-1:PG_SHIFT]), .key_ctx(lk_ctx), .key_glob(1'b0),
    .match(lk_match)
  );

  tlb_cam #(.NUM_ENT(NUM_ENT), .VPN_W(VPN_W), .CTX_W(CTX_W)) mnt_cam_i (
    .ent_vld(vld_q), .ent_glob(glob_q), .ent_vpn(vpn_q), .ent_ctx(ctx_q),
    .key_vpn(mnt_va[VA_W-1:PG_SHIFT]), .key_ctx(mnt_ctx), .key_glob(mnt_glob),
    .match(mnt_match)
  );

  tlb_lru #(.NUM_ENT(NUM_ENT)) lru_i (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .ent_vld(vld_q), .ent_lock(lock_q), .vict_ok(vict_ok), .vict_idx(vict_idx)
  );

  // First set bit of each match vector
  always_comb begin
    lk_any = 1'b0;  lk_idx = '0;
    dup_any = 1'b0; dup_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (lk_match[i])  begin lk_any = 1'b1;  lk_idx = IW'(i);  end
      if (mnt_match[i]) begin dup_any = 1'b1; dup_idx = IW'(i); end
    end
  end

  assign lk_attr  = attr_q[lk_idx];
  assign lk_fault = lk_any & ((lk_write & ~lk_attr[ATTR_WR]) |
                              (lk_user  &  lk_attr[ATTR_PRIV]));

  // Maintenance next state
  always_comb begin
    vld_d      = vld_q;
    lock_d     = lock_q;
    glob_d     = glob_q;
    wr_en      = 1'b0;
    wr_idx     = dup_idx;
    ins_refuse = 1'b0;
    unique case (op)
      MOP_INSERT: begin
        if (dup_any) begin
          wr_en  = 1'b1;
          wr_idx = dup_idx;
          vld_d  = vld_q & ~mnt_match;
        end else if (vict_ok) begin
          wr_en  = 1'b1;
          wr_idx = vict_idx;
        end else begin
          ins_refuse = 1'b1;
        end
        if (wr_en) begin
          vld_d[wr_idx]  = mnt_attr[ATTR_VALID];
          lock_d[wr_idx] = mnt_attr[ATTR_VALID] & mnt_attr[ATTR_LOCK];
          glob_d[wr_idx] = mnt_glob;
        end
      end
      MOP_INVAL: begin
        vld_d  = vld_q & ~mnt_match;
        lock_d = lock_q & ~mnt_match;
      end
      MOP_FLUSH: begin
        for (int i = 0; i < NUM_ENT; i++) begin
          if (ctx_q[i] == mnt_ctx && !lock_q[i] && !glob_q[i]) vld_d[i] = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign touch_en  = wr_en | (lk_vld & lk_any);
  assign touch_idx = wr_en ? wr_idx : lk_idx;

  // Entry registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      lock_q <= '0;
      glob_q <= '0;
    end else begin
      vld_q  <= vld_d;
      lock_q <= lock_d;
      glob_q <= glob_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        vpn_q[i]  <= '0;
        ctx_q[i]  <= '0;
        attr_q[i] <= '0;
      end
    end else if (wr_en) begin
      vpn_q[wr_idx]  <= mnt_va[VA_W-1:PG_SHIFT];
      ctx_q[wr_idx]  <= mnt_ctx;
      attr_q[wr_idx] <= mnt_attr;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
      res_pa    <= '0;
      res_attr  <= '0;
      mnt_err   <= 1'b0;
    end else begin
      res_vld <= lk_vld;
      mnt_err <= ins_refuse;
      if (lk_vld) begin
        res_hit   <= lk_any;
        res_fault <= lk_fault;
        res_pa    <= lk_any ? {lk_attr[PA_W-1:PG_SHIFT], lk_va[PG_SHIFT-1:0]} : '0;
        res_attr  <= lk_any ? lk_attr : '0;
      end
    end
  end
endmodule

// File: rtl/assoc_tlb_chk.sv
module assoc_tlb_chk #(
  parameter int NUM_ENT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_vld,
  input logic [63:0]        lk_va,
  input logic               res_vld,
  input logic               res_hit,
  input logic               res_fault,
  input logic [40:0]        res_pa,
  input logic [1:0]         mnt_op,
  input logic               mnt_err,
  input logic [NUM_ENT-1:0] lk_match,
  input logic [NUM_ENT-1:0] vld_q,
  input logic [NUM_ENT-1:0] lock_q
);
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld |=> res_vld); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |=> !res_vld); // R2
  AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit) |-> res_pa[12:0] == $past(lk_va[12:0])); // R2
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> res_hit); // R4
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R5
  AST_LOCKED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(vld_q & lock_q) & ~vld_q) != '0) |-> ($past(mnt_op) == 2'd1 || $past(mnt_op) == 2'd2)); // R9
  AST_ERR_FROM_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_err |-> $past(mnt_op) == 2'd1); // R10
endmodule

bind assoc_tlb assoc_tlb_chk #(.NUM_ENT(NUM_ENT)) chk_i (.*);

// File: tb/assoc_tlb_tb_top.sv
module assoc_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 16;

  logic        clk, rst_n;
  logic        lk_vld, lk_write, lk_user;
  logic [63:0] lk_va;
  logic [12:0] lk_ctx;
  logic        res_vld, res_hit, res_fault;
  logic [40:0] res_pa;
  logic [63:0] res_attr;
  logic [1:0]  mnt_op;
  logic [63:0] mnt_va, mnt_attr;
  logic [12:0] mnt_ctx;
  logic        mnt_glob, mnt_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  assoc_tlb dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Attribute word: valid 63, size 62:61, ppn 40:13, lock 6, priv 2, writable 1
  function automatic logic [63:0] mk_attr(input logic [27:0] ppn, input bit lock,
                                          input bit priv, input bit wr, input logic [1:0] sz);
    mk_attr = {1'b1, sz, 20'd0, ppn, 6'd0, lock, 3'd0, priv, wr, 1'b0};
  endfunction

  function automatic logic [63:0] pva(input int page);
    pva = 64'h0000_0123_0000_0000 + (64'(page) << 13);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic lookup(input logic [63:0] va, input logic [12:0] ctx, input bit wr, input bit usr);
    lk_vld = 1'b1; lk_va = va; lk_ctx = ctx; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_vld = 1'b0;
  endtask

  task automatic mnt(input logic [1:0] op, input logic [63:0] va, input logic [12:0] ctx,
                     input bit glob, input logic [63:0] attr);
    mnt_op = op; mnt_va = va; mnt_ctx = ctx; mnt_glob = glob; mnt_attr = attr;
    @(negedge clk);
    mnt_op = 2'd0;
  endtask

  task automatic expect_hit(input logic [63:0] va, input logic [12:0] ctx, input logic [27:0] ppn, input string req);
    lookup(va, ctx, 1'b0, 1'b0);
    chk(res_vld && res_hit, req, {62'd0, res_vld, res_hit}, 64'd3);
    chk(res_pa == {ppn, va[12:0]}, req, 64'(res_pa), 64'({ppn, va[12:0]}));
  endtask

  task automatic expect_miss(input logic [63:0] va, input logic [12:0] ctx, input string req);
    lookup(va, ctx, 1'b0, 1'b0);
    chk(res_vld && !res_hit && !res_fault, req, {61'd0, res_vld, res_hit, res_fault}, 64'd4);
  endtask

  task automatic t_reset();
    chk(!mnt_err && !res_vld, "R1 reset outputs", {62'd0, mnt_err, res_vld}, 64'd0);
    expect_miss(pva(0), 13'd0, "R1 empty after reset");
  endtask

  task automatic t_basic();
    mnt(2'd1, pva(3), 13'd7, 1'b0, mk_attr(28'h00abcde, 0, 0, 1, 2'd0));
    expect_hit(pva(3) | 64'h1a5, 13'd7, 28'h00abcde, "R2 hit translate");
    chk(res_attr == mk_attr(28'h00abcde, 0, 0, 1, 2'd0), "R2 attr out", res_attr, mk_attr(28'h00abcde, 0, 0, 1, 2'd0));
    expect_miss(pva(3), 13'd8, "R3 context mismatch");
    expect_miss(pva(4), 13'd7, "R3 page mismatch");
    mnt(2'd1, pva(9), 13'd1, 1'b1, mk_attr(28'h0000111, 0, 0, 1, 2'd0));
    expect_hit(pva(9), 13'd1234, 28'h0000111, "R3 global any context");
  endtask

  task automatic t_fault();
    mnt(2'd1, pva(20), 13'd2, 1'b0, mk_attr(28'h0000020, 0, 1, 0, 2'd0));
    lookup(pva(20), 13'd2, 1'b0, 1'b0);
    chk(res_hit && !res_fault, "R4 kernel read ok", {62'd0, res_hit, res_fault}, 64'd2);
    lookup(pva(20), 13'd2, 1'b1, 1'b0);
    chk(res_hit && res_fault, "R4 write to read-only", {62'd0, res_hit, res_fault}, 64'd3);
    lookup(pva(20), 13'd2, 1'b0, 1'b1);
    chk(res_hit && res_fault, "R4 user to privileged", {62'd0, res_hit, res_fault}, 64'd3);
    lookup(pva(21), 13'd2, 1'b1, 1'b1);
    chk(!res_hit && !res_fault, "R4 miss no fault", {62'd0, res_hit, res_fault}, 64'd0);
  endtask

  task automatic t_dup_inval();
    mnt(2'd1, pva(30), 13'd4, 1'b0, mk_attr(28'h0000aaa, 0, 0, 1, 2'd0));
    mnt(2'd1, pva(30), 13'd4, 1'b0, mk_attr(28'h0000bbb, 0, 0, 1, 2'd0));
    expect_hit(pva(30), 13'd4, 28'h0000bbb, "R5 overwrite in place");
    mnt(2'd2, pva(30), 13'd4, 1'b0, 64'd0);
    expect_miss(pva(30), 13'd4, "R5 R6 single copy invalidated");
    mnt(2'd1, pva(31), 13'd4, 1'b0, mk_attr(28'h0000ccc, 1, 0, 1, 2'd0));
    mnt(2'd2, pva(31), 13'd4, 1'b0, 64'd0);
    expect_miss(pva(31), 13'd4, "R6 locked entry invalidated");
    mnt(2'd1, pva(32), 13'd4, 1'b0, mk_attr(28'h0000ddd, 0, 0, 1, 2'd0) & ~(64'd1 << 63));
    expect_miss(pva(32), 13'd4, "R12 insert with valid clear");
  endtask

  task automatic t_flush();
    do_reset();
    mnt(2'd1, pva(1), 13'd5, 1'b0, mk_attr(28'h1, 0, 0, 1, 2'd0));
    mnt(2'd1, pva(2), 13'd5, 1'b0, mk_attr(28'h2, 1, 0, 1, 2'd0));
    mnt(2'd1, pva(3), 13'd5, 1'b1, mk_attr(28'h3, 0, 0, 1, 2'd0));
    mnt(2'd1, pva(4), 13'd6, 1'b0, mk_attr(28'h4, 0, 0, 1, 2'd0));
    mnt(2'd3, 64'd0, 13'd5, 1'b0, 64'd0);
    expect_miss(pva(1), 13'd5, "R7 unlocked flushed");
    expect_hit(pva(2), 13'd5, 28'h2, "R7 locked kept");
    expect_hit(pva(3), 13'd5, 28'h3, "R7 global kept");
    expect_hit(pva(4), 13'd6, 28'h4, "R7 other context kept");
  endtask

  task automatic t_lru();
    do_reset();
    for (int i = 0; i < NENT; i++) mnt(2'd1, pva(100 + i), 13'd1, 1'b0, mk_attr(28'(i + 16), 0, 0, 1, 2'd0));
    expect_hit(pva(100), 13'd1, 28'd16, "R8 fill and touch oldest");
    mnt(2'd1, pva(200), 13'd1, 1'b0, mk_attr(28'h77, 0, 0, 1, 2'd0));
    expect_miss(pva(101), 13'd1, "R8 second oldest evicted");
    expect_hit(pva(100), 13'd1, 28'd16, "R8 touched entry kept");
    expect_hit(pva(200), 13'd1, 28'h77, "R8 new entry present");
  endtask

  task automatic t_lock();
    do_reset();
    mnt(2'd1, pva(100), 13'd1, 1'b0, mk_attr(28'd50, 1, 0, 1, 2'd0));
    for (int i = 1; i < NENT; i++) mnt(2'd1, pva(100 + i), 13'd1, 1'b0, mk_attr(28'(i + 50), 0, 0, 1, 2'd0));
    mnt(2'd1, pva(300), 13'd1, 1'b0, mk_attr(28'd99, 0, 0, 1, 2'd0));
    expect_hit(pva(100), 13'd1, 28'd50, "R9 locked oldest kept");
    expect_miss(pva(101), 13'd1, "R9 oldest unlocked evicted");
  endtask

  task automatic t_full_lock();
    do_reset();
    for (int i = 0; i < NENT; i++) mnt(2'd1, pva(400 + i), 13'd2, 1'b0, mk_attr(28'(i + 80), 1, 0, 1, 2'd0));
    chk(!mnt_err, "R10 no error while free", {63'd0, mnt_err}, 64'd0);
    mnt(2'd1, pva(500), 13'd2, 1'b0, mk_attr(28'd7, 0, 0, 1, 2'd0));
    chk(mnt_err, "R10 error raised", {63'd0, mnt_err}, 64'd1);
    @(negedge clk);
    chk(!mnt_err, "R10 error one cycle", {63'd0, mnt_err}, 64'd0);
    expect_miss(pva(500), 13'd2, "R10 new page not inserted");
    expect_hit(pva(405), 13'd2, 28'd85, "R10 contents unchanged");
  endtask

  task automatic t_size();
    do_reset();
    mnt(2'd1, pva(600), 13'd3, 1'b0, mk_attr(28'd600, 0, 0, 1, 2'd3));
    expect_hit(pva(600) | 64'h1fff, 13'd3, 28'd600, "R11 same 8K page hits");
    expect_miss(pva(601), 13'd3, "R11 size code ignored");
  endtask

  initial begin
    rst_n = 1'b0; lk_vld = 1'b0; lk_va = '0; lk_ctx = '0; lk_write = 1'b0; lk_user = 1'b0;
    mnt_op = 2'd0; mnt_va = '0; mnt_ctx = '0; mnt_glob = 1'b0; mnt_attr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fault();
    t_dup_inval();
    t_flush();
    t_lru();
    t_lock();
    t_full_lock();
    t_size();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule